// File: doc/BRIEF.md
# Time-Shared Polyphase Channelizer Front End

This block sits ahead of an M-point FFT in a filter-bank channelizer. A stream of complex samples (16-bit signed I and Q) is dealt by a commutator into M branches, so each branch runs at one M-th of the input rate. No mixer and no oscillator are involved. The shift of each channel to baseband comes from the aliasing of the decimated branches together with the FFT that follows. Once a full block of M samples has arrived, one shared 4-tap FIR segment is stepped through the M branches, one branch per clock. It emits the M branch results that form one FFT input vector.

The coefficients live in a table outside the block. In each cycle the block presents the active channel and the branch being filtered. The table answers combinationally, in one of two forms. The first is a full-precision 16-bit tap set. The second is a quantized set, in which every tap is up to two signed power-of-two terms, so each product reduces to shifts and additions. A quantize input chooses between the two forms. The branch count, the channel and the quantize setting can be changed while the block runs. A new setting is taken up only at a clean block boundary, and taking it up clears the branch histories.

Top module: `polyphase_frontend`

## Requirements
- R1: While reset is low and in the first cycle after it, `out_valid` is 0 and `out_branch`, `out_i` and `out_q` are 0.
- R2: The branch count M is 4, 8 or 16 for a `cfg_msel` of 0, 1 or 2, and 16 for a value of 3. The sample accepted at position p of a block (counting from 0) enters branch p.
- R3: The clock edge that accepts a block's last sample is followed by exactly M consecutive cycles of `out_valid` high, beginning at the next edge, with `out_branch` going 0, 1, ... M-1.
- R4: With quantize off, a branch result is sum over t of h[t]·x[t]. Here x[0] is that branch's newest sample, x[t] the one t samples older, and h[t] the signed value `coef_full[16t+15:16t]`. I and Q use the same taps and the result is 35 bits signed.
- R5: With quantize on, tap t is `coef_spt[12t+11:12t]`, made of two 6-bit terms: bits [5:0] and [11:6]. In each term, bit 5 enables it, bit 4 negates it and bits [3:0] give a shift s. An enabled term adds ±x·2^(15−s), which matches a full-precision coefficient of ±2^(−s).
- R6: `coef_chan` shows the active channel, and `coef_branch` shows the branch whose result is registered at the next edge.
- R7: A change on `cfg_msel`, `cfg_chan` or `cfg_quant` is taken up only in a cycle where no block is partly received and no branch results are still pending. A block already under way is finished entirely with the old setting.
- R8: When a new setting is taken up, every branch history is cleared to zero. A sample accepted in that same cycle becomes the only nonzero entry of branch 0.
- R9: Cycles with `in_valid` low do not change any branch history or the block position, whatever is on `in_i` and `in_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample present |
| in_i | input | 16 | In-phase sample, signed |
| in_q | input | 16 | Quadrature sample, signed |
| cfg_msel | input | 2 | Branch count select |
| cfg_chan | input | 4 | Channel select |
| cfg_quant | input | 1 | 1 = shift-and-add taps, 0 = full-precision taps |
| coef_chan | output | 4 | Channel for the coefficient lookup |
| coef_branch | output | 4 | Branch for the coefficient lookup |
| coef_full | input | 64 | Full-precision taps for that branch |
| coef_spt | input | 48 | Quantized taps for that branch |
| out_valid | output | 1 | Branch result valid |
| out_branch | output | 4 | Index of the branch result |
| out_i | output | 35 | Filtered in-phase result |
| out_q | output | 35 | Filtered quadrature result |

## Verification
The assertions assume three things about the inputs. Samples arrive at most one per clock. The coefficient table answers within the same cycle. The next block is never completed before the previous block's M results have been emitted. The stimulus keeps to these by driving one sample per call, holding the table as a pure function of `coef_chan` and `coef_branch`, and sending at most one block back to back with the results of the previous one. Setting changes are made both while idle and in the middle of a block, so that the point where a new setting is taken up, and the clearing that goes with it, can both be seen at the outputs.

// File: rtl/pfe_pkg.sv
// Package: shared constants, term layout and branch-count decode for the
// polyphase front end. Assumes the branch-count select is 2 bits wide.
package pfe_pkg;

    localparam int SHIFT_W = 4;
    localparam int TERM_W  = SHIFT_W + 2;

    // One signed power-of-two term of a quantized tap
    typedef struct packed {
        logic               en;
        logic               neg;
        logic [SHIFT_W-1:0] sh;
    } spt_term_t;

    // Branch count for a select value, clamped to the supported maximum
    function automatic int branch_count(input logic [1:0] sel,
                                        input int min_log2,
                                        input int max_log2);
        int l2;
        l2 = min_log2 + int'(sel);
        if (l2 > max_log2) l2 = max_log2;
        return 1 << l2;
    endfunction

endpackage

// File: rtl/pfe_sequencer.sv
// Sequencer: keeps the active setting, steps the commutator position and
// runs the filter pass over the branches once a block is complete.
// Assumes at most one sample per cycle, and that a block is not completed
// before the previous pass has ended (except on the pass's last cycle).
module pfe_sequencer #(
    parameter int MAX_LOG2 = 4,
    parameter int MIN_LOG2 = 2,
    parameter int CHW      = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [1:0]          cfg_msel,
    input  logic [CHW-1:0]      cfg_chan,
    input  logic                cfg_quant,
    output logic [CHW-1:0]      act_chan,
    output logic                act_quant,
    output logic                clr,
    output logic                wr_en,
    output logic [MAX_LOG2-1:0] wr_branch,
    output logic                cmp_go,
    output logic [MAX_LOG2-1:0] cmp_branch
);
    import pfe_pkg::*;

    localparam int BW    = MAX_LOG2;
    localparam int CFG_W = 2 + CHW + 1;

    logic [1:0]     act_msel;
    logic [CHW-1:0] act_chan_r;
    logic           act_q_r;
    logic [CFG_W-1:0] act_cfg, req_cfg;
    logic [BW-1:0]  pos, cnt;
    logic           busy;
    logic           apply_w, last_w;
    logic [BW-1:0]  m_last_act, m_last_eff;

    // Decode the block length and detect the boundary update and block end
    always_comb begin
        act_cfg    = {act_msel, act_chan_r, act_q_r};
        req_cfg    = {cfg_msel, cfg_chan, cfg_quant};
        apply_w    = (pos == '0) && !busy && (req_cfg != act_cfg);
        m_last_act = BW'(branch_count(act_msel, MIN_LOG2, MAX_LOG2) - 1);
        m_last_eff = apply_w ? BW'(branch_count(cfg_msel, MIN_LOG2, MAX_LOG2) - 1)
                             : m_last_act;
        last_w     = in_valid && (pos == m_last_eff);
    end

    // Active setting, replaced only at an idle block boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_msel   <= '0;
            act_chan_r <= '0;
            act_q_r    <= 1'b0;
        end else if (apply_w) begin
            act_msel   <= cfg_msel;
            act_chan_r <= cfg_chan;
            act_q_r    <= cfg_quant;
        end
    end

    // Commutator position within the current input block
    always_ff @(posedge clk) begin
        if (!rst_n)        pos <= '0;
        else if (last_w)   pos <= '0;
        else if (in_valid) pos <= pos + BW'(1);
    end

    // Filter pass: one branch per cycle after each completed block
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (last_w) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (busy) begin
            if (cnt == m_last_act) busy <= 1'b0;
            else                   cnt  <= cnt + BW'(1);
        end
    end

    assign act_chan   = act_chan_r;
    assign act_quant  = act_q_r;
    assign clr        = apply_w;
    assign wr_en      = in_valid;
    assign wr_branch  = pos;
    assign cmp_go     = busy;
    assign cmp_branch = cnt;

    // R2: the commutator never points past the active branch count
    assert_pos_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pos <= m_last_act);

    // R7: the active setting moves only out of an idle block boundary
    assert_cfg_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (act_cfg != $past(act_cfg)) |-> $past(pos == '0 && !busy));

endmodule

// File: rtl/pfe_delay_bank.sv
// Delay bank: one TAPS-deep I/Q history per branch. A write shifts the
// selected branch; a clear zeroes all branches (keeping a same-cycle write).
// Assumes TAPS >= 2. Tap 0 of a read is the branch's newest sample.
module pfe_delay_bank #(
    parameter int DW       = 16,
    parameter int TAPS     = 4,
    parameter int MAX_LOG2 = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 wr_en,
    input  logic [MAX_LOG2-1:0]  wr_branch,
    input  logic [DW-1:0]        din_i,
    input  logic [DW-1:0]        din_q,
    input  logic [MAX_LOG2-1:0]  rd_branch,
    output logic [TAPS*DW-1:0]   rd_i,
    output logic [TAPS*DW-1:0]   rd_q
);
    localparam int NB = 1 << MAX_LOG2;
    localparam int LW = TAPS * DW;

    logic [LW-1:0] line_i [NB];
    logic [LW-1:0] line_q [NB];
    logic [NB-1:0] hit;

    // Branch selected by the commutator for this cycle's sample
    always_comb begin
        for (int b = 0; b < NB; b++) hit[b] = wr_en && (wr_branch == MAX_LOG2'(b));
    end

    // History update: clear on a setting change, shift on a write
    always_ff @(posedge clk) begin
        for (int b = 0; b < NB; b++) begin
            if (!rst_n) begin
                line_i[b] <= '0;
                line_q[b] <= '0;
            end else if (clr) begin
                line_i[b] <= hit[b] ? LW'(din_i) : '0;
                line_q[b] <= hit[b] ? LW'(din_q) : '0;
            end else if (hit[b]) begin
                line_i[b] <= {line_i[b][LW-DW-1:0], din_i};
                line_q[b] <= {line_q[b][LW-DW-1:0], din_q};
            end
        end
    end

    assign rd_i = line_i[rd_branch];
    assign rd_q = line_q[rd_branch];

    // R8: after a clear with no sample, every history reads back as zero
    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr && !wr_en) |-> (rd_i == '0 && rd_q == '0));

endmodule

// File: rtl/pfe_tap_mac.sv
// Tap sum: combinational TAPS-term dot product of one branch history with
// either full-precision coefficients or two-term shift-and-add taps.
// Assumes the shift field never exceeds CW-1.
module pfe_tap_mac #(
    parameter int DW    = 16,
    parameter int CW    = 16,
    parameter int TAPS  = 4,
    parameter int ACC_W = DW + CW + 3
) (
    input  logic                              quant,
    input  logic [TAPS*DW-1:0]                x,
    input  logic [TAPS*CW-1:0]                coef_full,
    input  logic [TAPS*2*pfe_pkg::TERM_W-1:0] coef_spt,
    output logic signed [ACC_W-1:0]           acc
);
    import pfe_pkg::*;

    localparam int FRAC  = CW - 1;
    localparam int TAP_W = 2 * TERM_W;

    logic signed [ACC_W-1:0] tap_val [TAPS];

    for (genvar t = 0; t < TAPS; t++) begin : g_tap
        logic signed [DW-1:0]    xs;
        logic signed [CW-1:0]    hs;
        logic signed [ACC_W-1:0] xe, p_full, v0, v1;
        spt_term_t               t0, t1;

        assign xs     = x[t*DW +: DW];
        assign hs     = coef_full[t*CW +: CW];
        assign t0     = spt_term_t'(coef_spt[t*TAP_W +: TERM_W]);
        assign t1     = spt_term_t'(coef_spt[t*TAP_W + TERM_W +: TERM_W]);
        assign xe     = ACC_W'(xs);
        assign p_full = xe * ACC_W'(hs);

        // First power-of-two term of this tap
        always_comb begin
            v0 = '0;
            if (t0.en) begin
                v0 = xe <<< (FRAC - int'(t0.sh));
                if (t0.neg) v0 = -v0;
            end
        end

        // Second power-of-two term of this tap
        always_comb begin
            v1 = '0;
            if (t1.en) begin
                v1 = xe <<< (FRAC - int'(t1.sh));
                if (t1.neg) v1 = -v1;
            end
        end

        assign tap_val[t] = quant ? (v0 + v1) : p_full;
    end

    // Sum of all tap contributions
    always_comb begin
        acc = '0;
        for (int t = 0; t < TAPS; t++) acc = acc + tap_val[t];
    end

endmodule

// File: rtl/polyphase_frontend.sv
// Top: time-shared polyphase front end. The commutator fills the branch
// histories; after each block one shared tap sum walks the branches, and its
// result is registered together with the branch index. Assumes the external
// coefficient table answers combinationally to coef_chan / coef_branch.
module polyphase_frontend #(
    parameter int DW       = 16,
    parameter int CW       = 16,
    parameter int TAPS     = 4,
    parameter int MAX_LOG2 = 4,
    parameter int MIN_LOG2 = 2,
    parameter int CHW      = 4
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  in_valid,
    input  logic [DW-1:0]                         in_i,
    input  logic [DW-1:0]                         in_q,
    input  logic [1:0]                            cfg_msel,
    input  logic [CHW-1:0]                        cfg_chan,
    input  logic                                  cfg_quant,
    output logic [CHW-1:0]                        coef_chan,
    output logic [MAX_LOG2-1:0]                   coef_branch,
    input  logic [TAPS*CW-1:0]                    coef_full,
    input  logic [TAPS*2*pfe_pkg::TERM_W-1:0]     coef_spt,
    output logic                                  out_valid,
    output logic [MAX_LOG2-1:0]                   out_branch,
    output logic [DW+CW+2:0]                      out_i,
    output logic [DW+CW+2:0]                      out_q
);
    localparam int ACC_W = DW + CW + 3;
    localparam int BW    = MAX_LOG2;

    logic              act_quant, clr, wr_en, cmp_go;
    logic [BW-1:0]     wr_branch, cmp_branch;
    logic [TAPS*DW-1:0] hist_i, hist_q;
    logic signed [ACC_W-1:0] acc_i, acc_q;

    pfe_sequencer #(.MAX_LOG2(MAX_LOG2), .MIN_LOG2(MIN_LOG2), .CHW(CHW)) u_seq (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .cfg_msel(cfg_msel), .cfg_chan(cfg_chan), .cfg_quant(cfg_quant),
        .act_chan(coef_chan), .act_quant(act_quant), .clr(clr),
        .wr_en(wr_en), .wr_branch(wr_branch),
        .cmp_go(cmp_go), .cmp_branch(cmp_branch)
    );

    pfe_delay_bank #(.DW(DW), .TAPS(TAPS), .MAX_LOG2(MAX_LOG2)) u_bank (
        .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .wr_branch(wr_branch),
        .din_i(in_i), .din_q(in_q), .rd_branch(cmp_branch),
        .rd_i(hist_i), .rd_q(hist_q)
    );

    pfe_tap_mac #(.DW(DW), .CW(CW), .TAPS(TAPS), .ACC_W(ACC_W)) u_mac_i (
        .quant(act_quant), .x(hist_i), .coef_full(coef_full),
        .coef_spt(coef_spt), .acc(acc_i)
    );

    pfe_tap_mac #(.DW(DW), .CW(CW), .TAPS(TAPS), .ACC_W(ACC_W)) u_mac_q (
        .quant(act_quant), .x(hist_q), .coef_full(coef_full),
        .coef_spt(coef_spt), .acc(acc_q)
    );

    assign coef_branch = cmp_branch;

    // Output register: one branch result per cycle of the filter pass
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_branch <= '0;
            out_i      <= '0;
            out_q      <= '0;
        end else begin
            out_valid <= cmp_go;
            if (cmp_go) begin
                out_branch <= cmp_branch;
                out_i      <= acc_i;
                out_q      <= acc_q;
            end
        end
    end

    // R3: a run of results always opens with branch 0
    assert_first_branch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (out_branch == '0));

    // R3: any later branch directly follows its predecessor
    assert_branch_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_branch != '0) |->
            ($past(out_valid) && out_branch == $past(out_branch) + BW'(1)));

endmodule

// File: tb/test_polyphase_frontend.sv
// Directed bench: one task per scenario, each checking its own results
// against a model built from the requirements.
module test_polyphase_frontend;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_i = '0, in_q = '0;
    logic [1:0]  cfg_msel = '0;
    logic [3:0]  cfg_chan = '0;
    logic        cfg_quant = 1'b0;
    logic [3:0]  coef_chan, coef_branch;
    logic [63:0] coef_full;
    logic [47:0] coef_spt;
    logic        out_valid;
    logic [3:0]  out_branch;
    logic [34:0] out_i, out_q;

    int checks = 0;
    int errors = 0;

    longint hist_i [16][4];
    longint hist_q [16][4];
    longint exp_i [2][16];
    longint exp_q [2][16];
    logic [1:0] sel_act = '0;
    int  chan_act = 0;
    bit  q_act = 1'b0;
    int  m_act = 4;

    always #2.5 clk = ~clk;

    polyphase_frontend i_polyphase_frontend (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .cfg_msel(cfg_msel), .cfg_chan(cfg_chan), .cfg_quant(cfg_quant),
        .coef_chan(coef_chan), .coef_branch(coef_branch),
        .coef_full(coef_full), .coef_spt(coef_spt),
        .out_valid(out_valid), .out_branch(out_branch), .out_i(out_i), .out_q(out_q)
    );

    function automatic int hfull(int ch, int br, int t);
        return (((ch * 7 + br * 3 + t * 5) % 23) - 11) * 1500;
    endfunction

    function automatic logic [11:0] spt(int ch, int br, int t);
        logic [5:0] a, b;
        a = {1'b1, 1'(((ch + br + t) % 2) == 1), 4'((ch + br + t) % 8 + 1)};
        b = {1'((br + t) % 3 != 0), 1'(t % 2 == 0), 4'((ch + 2 * t) % 16)};
        return {b, a};
    endfunction

    // Coefficient table owned by the bench
    always_comb begin
        for (int t = 0; t < 4; t++) begin
            coef_full[t*16 +: 16] = 16'(hfull(int'(coef_chan), int'(coef_branch), t));
            coef_spt[t*12 +: 12]  = spt(int'(coef_chan), int'(coef_branch), t);
        end
    end

    function automatic int mcount(logic [1:0] s);
        return (s == 2'd0) ? 4 : (s == 2'd1) ? 8 : 16;
    endfunction

    function automatic longint term_val(longint x, logic [5:0] c);
        longint v;
        if (!c[5]) return 0;
        v = x * (longint'(1) <<< (15 - int'(c[3:0])));
        return c[4] ? -v : v;
    endfunction

    function automatic longint branch_out(int br, bit use_q);
        longint s, x;
        logic [11:0] c;
        s = 0;
        for (int t = 0; t < 4; t++) begin
            x = use_q ? hist_q[br][t] : hist_i[br][t];
            if (q_act) begin
                c = spt(chan_act, br, t);
                s += term_val(x, c[5:0]) + term_val(x, c[11:6]);
            end else begin
                s += x * longint'(hfull(chan_act, br, t));
            end
        end
        return s;
    endfunction

    function automatic int samp(int base, int k, int salt);
        return ((base + k * 4099 + salt * 977) % 65536) - 32768;
    endfunction

    task automatic chk(bit ok, string req, longint act, longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // Bring the model's active setting in line after an idle boundary
    task automatic sync();
        if ({cfg_msel, cfg_chan, cfg_quant} != {sel_act, 4'(chan_act), q_act}) begin
            for (int b = 0; b < 16; b++)
                for (int t = 0; t < 4; t++) begin
                    hist_i[b][t] = 0;
                    hist_q[b][t] = 0;
                end
            sel_act  = cfg_msel;
            chan_act = int'(cfg_chan);
            q_act    = cfg_quant;
            m_act    = mcount(cfg_msel);
        end
    endtask

    task automatic set_cfg(logic [1:0] s, int ch, bit q);
        @(negedge clk);
        cfg_msel = s; cfg_chan = 4'(ch); cfg_quant = q;
        @(posedge clk);
        @(posedge clk);
        #1 sync();
    endtask

    task automatic put(int vi, int vq, int gap);
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            in_valid = 1'b0; in_i = 16'h7ABC; in_q = 16'h8123;
        end
        @(negedge clk);
        in_valid = 1'b1; in_i = 16'(vi); in_q = 16'(vq);
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    // Send one block; optionally change the setting inputs mid-block
    task automatic send_block(int base, int gap, int bank, int chg_at,
                              logic [1:0] ns, int nc, bit nq);
        int vi, vq;
        for (int k = 0; k < m_act; k++) begin
            if (k == chg_at) begin
                cfg_msel = ns; cfg_chan = 4'(nc); cfg_quant = nq;
            end
            vi = samp(base, k, 0);
            vq = samp(base, k, 1);
            put(vi, vq, gap);
            for (int t = 3; t > 0; t--) begin
                hist_i[k][t] = hist_i[k][t-1];
                hist_q[k][t] = hist_q[k][t-1];
            end
            hist_i[k][0] = vi;
            hist_q[k][0] = vq;
        end
        for (int b = 0; b < m_act; b++) begin
            exp_i[bank][b] = branch_out(b, 1'b0);
            exp_q[bank][b] = branch_out(b, 1'b1);
        end
    endtask

    task automatic collect(string req, int bank, int m, bit end_low);
        for (int k = 0; k < m; k++) begin
            @(posedge clk);
            #1;
            chk(out_valid == 1'b1, "R3 valid", longint'(out_valid), 1);
            chk(int'(out_branch) == k, "R3 order", longint'(out_branch), k);
            chk(longint'($signed(out_i)) == exp_i[bank][k], req,
                longint'($signed(out_i)), exp_i[bank][k]);
            chk(longint'($signed(out_q)) == exp_q[bank][k], req,
                longint'($signed(out_q)), exp_q[bank][k]);
        end
        if (end_low) begin
            @(posedge clk);
            #1;
            chk(out_valid == 1'b0, "R3 count", longint'(out_valid), 0);
            sync();
        end
    endtask

    task automatic t_reset();
        chk(out_valid == 1'b0, "R1 valid in reset", longint'(out_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk(out_valid == 1'b0, "R1 valid", longint'(out_valid), 0);
        chk(out_branch == '0, "R1 branch", longint'(out_branch), 0);
        chk(out_i == '0 && out_q == '0, "R1 data", longint'($signed(out_i)), 0);
        chk(coef_chan == '0, "R6 chan after reset", longint'(coef_chan), 0);
    endtask

    task automatic t_basic_m4();
        set_cfg(2'd0, 0, 1'b0);
        send_block(100, 0, 0, -1, 2'd0, 0, 1'b0);
        collect("R4 full m4 blk1", 0, 4, 1'b1);
        send_block(30000, 1, 0, -1, 2'd0, 0, 1'b0);
        collect("R2 R4 full m4 blk2", 0, 4, 1'b1);
    endtask

    task automatic t_quant_m8();
        set_cfg(2'd1, 3, 1'b1);
        send_block(5000, 0, 0, -1, 2'd0, 0, 1'b0);
        collect("R5 R8 quant m8 after clear", 0, 8, 1'b1);
        send_block(0, 0, 0, -1, 2'd0, 0, 1'b0);
        collect("R5 quant m8 blk2", 0, 8, 1'b1);
    endtask

    task automatic t_chan_switch();
        set_cfg(2'd1, 9, 1'b1);
        chk(coef_chan == 4'd9, "R6 coef_chan", longint'(coef_chan), 9);
        send_block(12345, 0, 0, -1, 2'd0, 0, 1'b0);
        collect("R6 channel 9 taps", 0, 8, 1'b1);
    endtask

    task automatic t_gaps_m16();
        set_cfg(2'd2, 5, 1'b0);
        send_block(777, 2, 0, -1, 2'd0, 0, 1'b0);
        collect("R9 gaps ignored m16", 0, 16, 1'b1);
    endtask

    task automatic t_sel3();
        set_cfg(2'd3, 2, 1'b1);
        send_block(40000, 0, 0, -1, 2'd0, 0, 1'b0);
        collect("R2 select 3 gives 16", 0, 16, 1'b1);
    endtask

    task automatic t_midblock();
        send_block(2222, 0, 0, 5, 2'd0, 1, 1'b0);
        collect("R7 old setting kept mid-block", 0, 16, 1'b1);
        chk(coef_chan == 4'd1, "R7 new channel after boundary", longint'(coef_chan), 1);
        send_block(9999, 0, 0, -1, 2'd0, 0, 1'b0);
        collect("R7 R8 new setting after boundary", 0, 4, 1'b1);
    endtask

    task automatic t_stream();
        send_block(31000, 0, 0, -1, 2'd0, 0, 1'b0);
        fork
            collect("R3 stream blk A", 0, 4, 1'b0);
            send_block(17, 0, 1, -1, 2'd0, 0, 1'b0);
        join
        collect("R3 stream blk B", 1, 4, 1'b1);
    endtask

    initial begin
        for (int b = 0; b < 16; b++)
            for (int t = 0; t < 4; t++) begin
                hist_i[b][t] = 0;
                hist_q[b][t] = 0;
            end
        repeat (4) @(posedge clk);
        t_reset();
        t_basic_m4();
        t_quant_m8();
        t_chan_switch();
        t_gaps_m16();
        t_sel3();
        t_midblock();
        t_stream();
        repeat (3) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule